// File: doc/BRIEF.md
# Length-Selected Serial Register Loader

This block is a write-only serial port that fills one of three parallel configuration registers: a 16-bit divide register, a 15-bit reference register and an 8-bit configuration register. The serial stream carries no address. The host pulls the active-low enable low, clocks in a number of bits with the most significant bit first, and raises the enable again. The number of bits clocked in picks the register. An 8-bit burst writes the configuration register. A 16-bit burst writes the divide register. A 15-bit or 24-bit burst writes the reference register; with 24 bits, only the last 15 are kept. Any other length changes nothing. The registers can therefore be written in any order, and a divide update takes one two-byte transfer from a byte-oriented master.

The serial clock, data and enable come from a host and are sampled in the system clock domain. They pass through a synchronizer, and the block detects the rising edges of the serial clock. The bits enter a 24-bit shift chain. The last bit of the chain is presented on a serial output, so the chain can be daisy-chained or read back. That output is driven only while a transfer is in progress. Each write to the divide register also raises a one-cycle restart strobe, which the counter chain downstream uses to reload itself.

A controller with three states runs each transfer:
- `ST_IDLE` waits for the enable. On the transition IDLE→SHIFT, taken when the enable is low, the bit counter clears.
- `ST_SHIFT` moves one bit in on each rising edge of the serial clock. On the transition SHIFT→COMMIT, taken when the enable is high, shifting stops.
- `ST_COMMIT` decodes the bit count and writes the selected register for one cycle. The transition COMMIT→IDLE is unconditional.

Top module: `sl_loader`

## Requirements
- R1: After reset the configuration register reads 0, the reference register reads 1 and the divide register reads 40. The restart strobe, the output enable and the serial output are all 0.
- R2: A bit is shifted in only on a rising edge of the serial clock while the enable (active low) is low. Serial clock edges while the enable is high change no register and no chain content.
- R3: A transfer of exactly 8 bits writes those 8 bits into the configuration register. The first bit sent lands in bit 7. The other two registers keep their values.
- R4: A transfer of exactly 16 bits writes the divide register, with the first bit in bit 15. In the same cycle the restart strobe goes high for exactly one clock. This also happens when the new value equals the old one.
- R5: A transfer of exactly 15 bits writes the reference register, with the first bit in bit 14.
- R6: A transfer of exactly 24 bits writes the reference register from the last 15 bits received. The first 9 bits are dropped.
- R7: A transfer of any other length changes no register and raises no strobe. This includes 7, 9, 17, 23 and more than 24 bits. The bit counter saturates at 25.
- R8: The serial output always equals the bit received 24 serial clocks earlier, which is the last stage of the chain and 0 after reset. The output enable is high only while a transfer is being shifted (state `ST_SHIFT`). It is low in any cycle in which a register is written.
- R9: With 2 synchronizer stages, the output enable rises 3 clocks after the enable input falls and falls 3 clocks after it rises. The selected register and the strobe change 4 clocks after the enable input rises.
- R10: The restart strobe fires only for divide-register writes. It never fires for configuration or reference writes, or for discarded transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host; data is taken on its rising edge |
| sdi | input | 1 | Serial data in, most significant bit first |
| sen_n | input | 1 | Active-low transfer enable; its rising edge commits the transfer |
| sdo | output | 1 | Last stage of the shift chain |
| sdo_oe | output | 1 | Drive enable for sdo; when low the pad is high-impedance |
| div_q | output | 16 | Divide register contents |
| ref_q | output | 15 | Reference register contents |
| cfg_q | output | 8 | Configuration register contents |
| jam_pulse | output | 1 | One-cycle strobe on each divide-register write |

## Verification
Some behaviours hold on every clock, and the assertions check those on every cycle:
- The divide register never changes without the strobe, and the strobe lasts one cycle and never coincides with a change to another register.
- No register is written while the output enable is high.
- The chain stays still whenever no transfer is active.
- The bit counter stays at or below its saturation value.

Other behaviours can only be shown by the bench's scenarios:
- which length selects which register;
- which bits of a 24-bit burst are kept;
- that lengths of 7, 9, 17, 23 and 30 bits leave every register unchanged;
- that serial clocks with the enable high are ignored;
- the exact cycle latencies and the serial echo.

The bench compares its own model of these against the design on every clock.

// File: rtl/sl_pkg.sv
package sl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } sl_state_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CFG  = 2'd1,
        TGT_DIV  = 2'd2,
        TGT_REF  = 2'd3
    } sl_target_e;

endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_flops
            logic [WIDTH-1:0] stg [STAGES];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end

            assign q = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sl_shift.sv
module sl_shift #(
    parameter int CHAIN_W = 24,
    parameter int CNT_MAX = 25,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               shift,
    input  logic               din,
    output logic [CHAIN_W-1:0] chain_q,
    output logic [CNT_W-1:0]   cnt_q
);

    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (shift) begin
            chain_q <= {chain_q[CHAIN_W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (shift && (cnt_q != CNT_TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sl_ctrl.sv
module sl_ctrl
    import sl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    input  logic sclk_lvl,
    output logic clr_cnt,
    output logic shift_en,
    output logic commit,
    output logic busy
);

    sl_state_e state_q;
    sl_state_e state_d;
    logic      sclk_prev;
    logic      sclk_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_lvl;
    end

    assign sclk_rise = sclk_lvl & ~sclk_prev;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!en_n) state_d = ST_SHIFT;
            ST_SHIFT:  if (en_n)  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        clr_cnt  = 1'b0;
        shift_en = 1'b0;
        commit   = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE:   clr_cnt = !en_n;
            ST_SHIFT: begin
                busy     = 1'b1;
                shift_en = sclk_rise & !en_n;
            end
            ST_COMMIT: commit = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/sl_regs.sv
module sl_regs
    import sl_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int REF_W   = 15,
    parameter int CFG_W   = 8,
    parameter int LONG_W  = 24,
    parameter int CNT_W   = 5,
    parameter int DIV_RST = 40,
    parameter int REF_RST = 1,
    parameter int CFG_RST = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [DIV_W-1:0] tail,
    input  logic [CNT_W-1:0] cnt,
    output logic [DIV_W-1:0] div_q,
    output logic [REF_W-1:0] ref_q,
    output logic [CFG_W-1:0] cfg_q,
    output logic             jam
);

    localparam logic [CNT_W-1:0] LEN_CFG  = CNT_W'(CFG_W);
    localparam logic [CNT_W-1:0] LEN_DIV  = CNT_W'(DIV_W);
    localparam logic [CNT_W-1:0] LEN_REF  = CNT_W'(REF_W);
    localparam logic [CNT_W-1:0] LEN_LONG = CNT_W'(LONG_W);

    sl_target_e tgt;

    always_comb begin
        tgt = TGT_NONE;
        if (commit) begin
            if (cnt == LEN_CFG)                          tgt = TGT_CFG;
            else if (cnt == LEN_DIV)                     tgt = TGT_DIV;
            else if ((cnt == LEN_REF) || (cnt == LEN_LONG)) tgt = TGT_REF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_W'(DIV_RST);
            ref_q <= REF_W'(REF_RST);
            cfg_q <= CFG_W'(CFG_RST);
            jam   <= 1'b0;
        end else begin
            jam <= (tgt == TGT_DIV);
            unique case (tgt)
                TGT_CFG:  cfg_q <= tail[CFG_W-1:0];
                TGT_DIV:  div_q <= tail;
                TGT_REF:  ref_q <= tail[REF_W-1:0];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/sl_loader.sv
module sl_loader #(
    parameter int DIV_W       = 16,
    parameter int REF_W       = 15,
    parameter int CFG_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_RST     = 40,
    parameter int REF_RST     = 1,
    parameter int CFG_RST     = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             sdi,
    input  logic             sen_n,
    output logic             sdo,
    output logic             sdo_oe,
    output logic [DIV_W-1:0] div_q,
    output logic [REF_W-1:0] ref_q,
    output logic [CFG_W-1:0] cfg_q,
    output logic             jam_pulse
);

    localparam int CHAIN_W = DIV_W + CFG_W;
    localparam int CNT_MAX = CHAIN_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [2:0]         raw_in;
    logic [2:0]         syn_in;
    logic               s_en_n;
    logic               s_sclk;
    logic               s_sdi;
    logic               clr_cnt;
    logic               shift_en;
    logic               commit;
    logic [CHAIN_W-1:0] chain_w;
    logic [CNT_W-1:0]   bitcnt_w;

    assign raw_in = {sen_n, sclk, sdi};
    assign s_en_n = syn_in[2];
    assign s_sclk = syn_in[1];
    assign s_sdi  = syn_in[0];

    sl_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    sl_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_n     (s_en_n),
        .sclk_lvl (s_sclk),
        .clr_cnt  (clr_cnt),
        .shift_en (shift_en),
        .commit   (commit),
        .busy     (sdo_oe)
    );

    sl_shift #(
        .CHAIN_W (CHAIN_W),
        .CNT_MAX (CNT_MAX),
        .CNT_W   (CNT_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_cnt),
        .shift   (shift_en),
        .din     (s_sdi),
        .chain_q (chain_w),
        .cnt_q   (bitcnt_w)
    );

    sl_regs #(
        .DIV_W   (DIV_W),
        .REF_W   (REF_W),
        .CFG_W   (CFG_W),
        .LONG_W  (CHAIN_W),
        .CNT_W   (CNT_W),
        .DIV_RST (DIV_RST),
        .REF_RST (REF_RST),
        .CFG_RST (CFG_RST)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .tail   (chain_w[DIV_W-1:0]),
        .cnt    (bitcnt_w),
        .div_q  (div_q),
        .ref_q  (ref_q),
        .cfg_q  (cfg_q),
        .jam    (jam_pulse)
    );

    assign sdo = chain_w[CHAIN_W-1];

endmodule

// File: rtl/sl_loader_chk.sv
module sl_loader_chk #(
    parameter int DIV_W   = 16,
    parameter int REF_W   = 15,
    parameter int CFG_W   = 8,
    parameter int CHAIN_W = 24,
    parameter int CNT_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sdo_oe,
    input logic               jam_pulse,
    input logic [DIV_W-1:0]   div_q,
    input logic [REF_W-1:0]   ref_q,
    input logic [CFG_W-1:0]   cfg_q,
    input logic [CHAIN_W-1:0] chain,
    input logic [CNT_W-1:0]   bitcnt
);

    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CHAIN_W + 1);

    // R4
    div_needs_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_q) |-> jam_pulse);

    // R4
    jam_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jam_pulse |=> !jam_pulse);

    // R10
    jam_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jam_pulse |-> ($stable(ref_q) && $stable(cfg_q)));

    // R3
    cfg_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> ($stable(ref_q) && !jam_pulse));

    // R8
    write_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ref_q) || !$stable(cfg_q) || jam_pulse) |-> !sdo_oe);

    // R2
    chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |=> $stable(chain));

    // R7
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= CNT_TOP);

endmodule

bind sl_loader sl_loader_chk #(
    .DIV_W   (DIV_W),
    .REF_W   (REF_W),
    .CFG_W   (CFG_W),
    .CHAIN_W (CHAIN_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdo_oe    (sdo_oe),
    .jam_pulse (jam_pulse),
    .div_q     (div_q),
    .ref_q     (ref_q),
    .cfg_q     (cfg_q),
    .chain     (chain_w),
    .bitcnt    (bitcnt_w)
);

// File: tb/test_sl_loader.sv
module test_sl_loader;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sen_n = 1'b1;
    logic        sdo;
    logic        sdo_oe;
    logic [15:0] div_q;
    logic [14:0] ref_q;
    logic [7:0]  cfg_q;
    logic        jam_pulse;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int jam_seen = 0;
    bit run_chk = 1'b0;

    // reference model state
    logic [15:0] e_div = 16'd40;
    logic [14:0] e_ref = 15'd1;
    logic [7:0]  e_cfg = 8'd0;
    logic [23:0] e_chain = 24'd0;
    logic        e_oe = 1'b0;
    logic        e_jam = 1'b0;
    int          p_at = -1;
    int          p_kind = 0;
    logic [23:0] p_val = '0;
    int          p_oe_at = -1;
    logic        p_oe_val = 1'b0;

    sl_loader i_sl_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .sen_n     (sen_n),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .div_q     (div_q),
        .ref_q     (ref_q),
        .cfg_q     (cfg_q),
        .jam_pulse (jam_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            if (cyc == p_oe_at) e_oe = p_oe_val;
            e_jam = 1'b0;
            if (cyc == p_at) begin
                case (p_kind)
                    1: e_cfg = p_val[7:0];
                    2: begin e_div = p_val[15:0]; e_jam = 1'b1; end
                    3: e_ref = p_val[14:0];
                    default: ;
                endcase
            end
            if (jam_pulse) jam_seen++;
            check(div_q == e_div, "R9", "divide register", div_q, e_div);
            check(ref_q == e_ref, "R9", "reference register", ref_q, e_ref);
            check(cfg_q == e_cfg, "R9", "config register", cfg_q, e_cfg);
            check(jam_pulse == e_jam, "R4", "restart strobe", jam_pulse, e_jam);
            check(sdo_oe == e_oe, "R8", "output enable", sdo_oe, e_oe);
        end
    end

    task automatic xfer(input int nbits, input logic [63:0] data);
        int p;
        @(posedge clk); #1;
        sen_n = 1'b0;
        p_oe_at = cyc + 3;
        p_oe_val = 1'b1;
        repeat (5) @(posedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            @(posedge clk); #1;
            sdi = data[i];
            sclk = 1'b0;
            repeat (3) @(posedge clk);
            #1 sclk = 1'b1;
            e_chain = {e_chain[22:0], data[i]};
            repeat (3) @(posedge clk);
            @(negedge clk);
            check(sdo == e_chain[23], "R8", "serial echo", sdo, e_chain[23]);
        end
        @(posedge clk); #1;
        sclk = 1'b0;
        repeat (3) @(posedge clk);
        #1 sen_n = 1'b1;
        p = cyc;
        p_oe_at = p + 3;
        p_oe_val = 1'b0;
        p_val = e_chain;
        if (nbits == 8)                      p_kind = 1;
        else if (nbits == 16)                p_kind = 2;
        else if (nbits == 15 || nbits == 24) p_kind = 3;
        else                                 p_kind = 0;
        p_at = p + 4;
        repeat (8) @(posedge clk);
    endtask

    task automatic idle_clocks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            sdi = i[0];
            sclk = 1'b1;
            repeat (3) @(posedge clk);
            #1 sclk = 1'b0;
            repeat (3) @(posedge clk);
        end
    endtask

    task automatic expect_regs(input string tag, input logic [15:0] d,
                               input logic [14:0] r, input logic [7:0] c);
        @(negedge clk);
        check(div_q == d, tag, "divide register", div_q, d);
        check(ref_q == r, tag, "reference register", ref_q, r);
        check(cfg_q == c, tag, "config register", cfg_q, c);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int j0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(div_q == 16'd40, "R1", "divide reset", div_q, 40);
        check(ref_q == 15'd1, "R1", "reference reset", ref_q, 1);
        check(cfg_q == 8'd0, "R1", "config reset", cfg_q, 0);
        check(jam_pulse == 1'b0, "R1", "strobe reset", jam_pulse, 0);
        check(sdo_oe == 1'b0, "R1", "output enable reset", sdo_oe, 0);
        check(sdo == 1'b0, "R1", "serial out reset", sdo, 0);
        run_chk = 1'b1;

        // R3 config write
        j0 = jam_seen;
        xfer(8, 64'hA5);
        expect_regs("R3", 16'd40, 15'd1, 8'hA5);
        check(jam_seen == j0, "R10", "strobe on config write", jam_seen - j0, 0);

        // R4 divide write with strobe
        j0 = jam_seen;
        xfer(16, 64'h1234);
        expect_regs("R4", 16'h1234, 15'd1, 8'hA5);
        check(jam_seen == j0 + 1, "R4", "strobe count", jam_seen - j0, 1);

        // R5 reference write
        j0 = jam_seen;
        xfer(15, 64'h4321);
        expect_regs("R5", 16'h1234, 15'h4321, 8'hA5);
        check(jam_seen == j0, "R10", "strobe on reference write", jam_seen - j0, 0);

        // R6 24-bit burst keeps the last 15 bits
        xfer(24, 64'hFF7ABC);
        expect_regs("R6", 16'h1234, 15'h7ABC, 8'hA5);

        // R7 discarded lengths
        j0 = jam_seen;
        xfer(7, 64'h55);
        xfer(9, 64'h1FF);
        xfer(17, 64'h1FFFF);
        xfer(23, 64'h7FFFFF);
        xfer(30, 64'h2AAA_AAAA);
        expect_regs("R7", 16'h1234, 15'h7ABC, 8'hA5);
        check(jam_seen == j0, "R7", "strobe on discarded transfer", jam_seen - j0, 0);

        // R2 serial clocks with enable high are ignored
        idle_clocks(6);
        expect_regs("R2", 16'h1234, 15'h7ABC, 8'hA5);
        check(sdo_oe == 1'b0, "R2", "output enable while idle", sdo_oe, 0);
        check(sdo == e_chain[23], "R2", "chain after idle clocks", sdo, e_chain[23]);

        // R4 rewrite of the same divide value still strobes
        xfer(16, 64'hFFFF);
        j0 = jam_seen;
        xfer(16, 64'hFFFF);
        expect_regs("R4", 16'hFFFF, 15'h7ABC, 8'hA5);
        check(jam_seen == j0 + 1, "R4", "strobe on equal value", jam_seen - j0, 1);

        // R3 second config write, R8 echo of previous contents checked per bit
        xfer(8, 64'h3C);
        expect_regs("R3", 16'hFFFF, 15'h7ABC, 8'h3C);

        run_chk = 1'b0;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule